// File: doc/BRIEF.md
# Activity-Reloaded Power-Management Countdown Timer

This block is a small countdown timer used by power-management logic to detect that a system has been idle for a chosen time. An 8-bit counter decrements once per period of a coarse time base. Three bases are available, all derived from a slow reference enable pulse that arrives every 1/16 second: every reference pulse, every 16 pulses (one second), or every 960 pulses (one minute). A fourth setting stops the timer.

Software starts a countdown with a reload strobe. Detected primary system activity can also restart the countdown, so the timer only expires after a stretch with no activity. When the count steps from one to zero, a sticky timeout flag is set. With automatic re-arming enabled, the counter is refilled at that moment and keeps running. Without it, the counter rests at zero. Each activity pulse also sets its own sticky flag. Each flag has an interrupt enable, and the two gated flags combine into one interrupt request. Both flags are cleared by write-one strobes.

Top module: `pm_idle_timer`

## Requirements
- R1: After reset, `tmo_sts`, `act_sts` and `irq` are 0, the count is 0 and the prescaler is at its start.
- R2: With `tbase` = 2'b00 the timer is disabled. Reference pulses do not change the count, and no timeout is raised.
- R3: `tbase` selects the decrement rate: 2'b01 decrements on every `ref_tick`, 2'b10 on every 16th, and 2'b11 on every 960th, counted from the last prescaler restart.
- R4: A `sw_load` pulse copies `reload_val` into the count and restarts the prescaler. A decrement from 1 to 0 sets `tmo_sts` in the same clock edge. A count of 0 never produces a timeout.
- R5: With `auto_rl_en` = 0, the count stays at 0 after expiry. No further timeout occurs until the next load.
- R6: With `auto_rl_en` = 1, expiry loads `reload_val` again. The timer expires again after `reload_val` more decrements.
- R7: An `act_pulse` with `act_rl_en` = 1 acts like `sw_load`. With `act_rl_en` = 0, it leaves the count and the prescaler untouched.
- R8: Every `act_pulse` sets `act_sts` at the next edge. `irq` is high whenever `act_sts` and `act_irq_en` are both 1.
- R9: `irq` is high whenever `tmo_sts` and `tmo_irq_en` are both 1. It is low when neither gated flag is active.
- R10: `clr_tmo` clears only `tmo_sts`, and `clr_act` clears only `act_sts`. A set condition in the same cycle wins over the clear.
- R11: Any change of `tbase` restarts the prescaler, so the first decrement after the change comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse every 1/16 s |
| tbase | input | 2 | Time-base select (00 off, 01 1/16 s, 10 1 s, 11 1 min) |
| reload_val | input | CNT_W | Value loaded into the count |
| auto_rl_en | input | 1 | Re-arm automatically on expiry |
| act_rl_en | input | 1 | Let activity reload the count |
| act_pulse | input | 1 | Primary activity detected (one cycle) |
| sw_load | input | 1 | Software reload strobe |
| tmo_irq_en | input | 1 | Route the timeout flag to `irq` |
| act_irq_en | input | 1 | Route the activity flag to `irq` |
| clr_tmo | input | 1 | Write-one clear of `tmo_sts` |
| clr_act | input | 1 | Write-one clear of `act_sts` |
| tmo_sts | output | 1 | Sticky timeout flag |
| act_sts | output | 1 | Sticky activity flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Two internal states can go wrong without showing at once: the count and the prescaler phase. A wrong count shows up as `tmo_sts` rising one or more decrements too early or too late. A prescaler left unrestarted shifts that edge by up to a whole period, which can be 959 reference pulses in the minute base. So each check samples `tmo_sts` exactly one decrement before and at the expected expiry. A flag that is stuck or never set is seen at `irq` in the cycle after the edge that should have changed it.

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int CNT_W   = 8,
  parameter int SEC_DIV = 16,
  parameter int MIN_DIV = 960
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [1:0]       tbase,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             auto_rl_en,
  input  logic             act_rl_en,
  input  logic             act_pulse,
  input  logic             sw_load,
  input  logic             tmo_irq_en,
  input  logic             act_irq_en,
  input  logic             clr_tmo,
  input  logic             clr_act,
  output logic             tmo_sts,
  output logic             act_sts,
  output logic             irq
);
  localparam int PRE_W = $clog2(MIN_DIV);

  logic [1:0]       tbase_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic [CNT_W-1:0] cnt;

  wire load    = sw_load | (act_pulse & act_rl_en);
  wire tb_chg  = tbase != tbase_q;
  wire restart = load | tb_chg;
  wire enabled = tbase != 2'b00;
  wire pre_end = pre_cnt == pre_lim;
  wire tick    = ref_tick & enabled & ~restart & pre_end;
  wire expire  = tick & (cnt == CNT_W'(1));

  always_comb begin
    case (tbase)
      2'b10:   pre_lim = PRE_W'(SEC_DIV - 1);
      2'b11:   pre_lim = PRE_W'(MIN_DIV - 1);
      default: pre_lim = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tbase_q <= 2'b00;
    else        tbase_q <= tbase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !enabled) pre_cnt <= '0;
    else if (ref_tick)                 pre_cnt <= pre_end ? '0 : pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (load)                     cnt <= reload_val;
    else if (expire)                   cnt <= auto_rl_en ? reload_val : '0;
    else if (tick && cnt != '0)        cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tmo_sts <= 1'b0;
    else if (expire)  tmo_sts <= 1'b1;
    else if (clr_tmo) tmo_sts <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         act_sts <= 1'b0;
    else if (act_pulse) act_sts <= 1'b1;
    else if (clr_act)   act_sts <= 1'b0;
  end

  assign irq = (tmo_sts & tmo_irq_en) | (act_sts & act_irq_en);
endmodule

module pm_idle_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       tbase,
  input logic             act_rl_en,
  input logic             act_pulse,
  input logic             sw_load,
  input logic             clr_tmo,
  input logic             tmo_sts,
  input logic             act_sts,
  input logic [CNT_W-1:0] cnt
);
  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbase == 2'b00 && !sw_load && !(act_pulse && act_rl_en)) |=> $stable(cnt));

  // R4
  expire_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_sts) |-> $past(cnt) == CNT_W'(1));

  // R8
  act_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> act_sts);

  // R10
  tmo_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_sts) |-> $past(clr_tmo));
endmodule

bind pm_idle_timer pm_idle_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tbase(tbase), .act_rl_en(act_rl_en),
  .act_pulse(act_pulse), .sw_load(sw_load), .clr_tmo(clr_tmo),
  .tmo_sts(tmo_sts), .act_sts(act_sts), .cnt(cnt)
);

// File: tb/pm_idle_timer_tb.sv
module pm_idle_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic [1:0] tbase = 2'b00;
  logic [7:0] reload_val = 8'd0;
  logic auto_rl_en = 1'b0, act_rl_en = 1'b0, act_pulse = 1'b0, sw_load = 1'b0;
  logic tmo_irq_en = 1'b0, act_irq_en = 1'b0, clr_tmo = 1'b0, clr_act = 1'b0;
  logic tmo_sts, act_sts, irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pm_idle_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tbase(tbase),
    .reload_val(reload_val), .auto_rl_en(auto_rl_en), .act_rl_en(act_rl_en),
    .act_pulse(act_pulse), .sw_load(sw_load), .tmo_irq_en(tmo_irq_en),
    .act_irq_en(act_irq_en), .clr_tmo(clr_tmo), .clr_act(clr_act),
    .tmo_sts(tmo_sts), .act_sts(act_sts), .irq(irq)
  );

  // {tbase[22:21], reload[20:13], auto[12], ref pulses[11:1], expected tmo_sts[0]}
  localparam logic [22:0] VEC [10] = '{
    {2'b01, 8'd3, 1'b0, 11'd2,   1'b0},  // R3 R4
    {2'b01, 8'd3, 1'b0, 11'd3,   1'b1},  // R3 R4
    {2'b10, 8'd2, 1'b0, 11'd31,  1'b0},  // R3
    {2'b10, 8'd2, 1'b0, 11'd32,  1'b1},  // R3
    {2'b11, 8'd1, 1'b0, 11'd959, 1'b0},  // R3
    {2'b11, 8'd1, 1'b0, 11'd960, 1'b1},  // R3
    {2'b01, 8'd0, 1'b0, 11'd6,   1'b0},  // R4 zero reload
    {2'b00, 8'd1, 1'b0, 11'd20,  1'b0},  // R2
    {2'b01, 8'd1, 1'b0, 11'd1,   1'b1},  // R4
    {2'b01, 8'd4, 1'b1, 11'd3,   1'b0}   // R6 before expiry
  };

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
  endtask

  task automatic strobe_load();
    @(negedge clk) begin sw_load = 1'b1; clr_tmo = 1'b1; clr_act = 1'b1; end
    @(negedge clk) begin sw_load = 1'b0; clr_tmo = 1'b0; clr_act = 1'b0; end
  endtask

  task automatic set_mode(input logic [1:0] tb, input logic [7:0] rv, input logic ar);
    @(negedge clk) begin tbase = tb; reload_val = rv; auto_rl_en = ar; end
    repeat (2) @(negedge clk);
  endtask

  task automatic act_once();
    @(negedge clk) act_pulse = 1'b1;
    @(negedge clk) act_pulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tmo_irq_en = 1'b1; act_irq_en = 1'b1;
    chk("R1 tmo_sts", tmo_sts, 1'b0);
    chk("R1 act_sts", act_sts, 1'b0);
    chk("R1 irq", irq, 1'b0);
    tmo_irq_en = 1'b0; act_irq_en = 1'b0;

    for (int v = 0; v < 10; v++) begin
      set_mode(VEC[v][22:21], VEC[v][20:13], VEC[v][12]);
      strobe_load();
      pulses(int'(VEC[v][11:1]));
      chk($sformatf("R3/R4 vector %0d", v), tmo_sts, VEC[v][0]);
    end

    // R6: auto re-arm gives repeated expiry
    set_mode(2'b01, 8'd2, 1'b1);
    strobe_load();
    pulses(2);
    chk("R6 first expiry", tmo_sts, 1'b1);
    @(negedge clk) clr_tmo = 1'b1;
    @(negedge clk) clr_tmo = 1'b0;
    pulses(1);
    chk("R6 mid second period", tmo_sts, 1'b0);
    pulses(1);
    chk("R6 second expiry", tmo_sts, 1'b1);

    // R5: no auto, timer rests at zero
    set_mode(2'b01, 8'd2, 1'b0);
    strobe_load();
    pulses(2);
    chk("R5 expiry", tmo_sts, 1'b1);
    @(negedge clk) clr_tmo = 1'b1;
    @(negedge clk) clr_tmo = 1'b0;
    pulses(6);
    chk("R5 stays expired-quiet", tmo_sts, 1'b0);

    // R7: activity reload enabled
    set_mode(2'b01, 8'd3, 1'b0);
    act_rl_en = 1'b1;
    strobe_load();
    pulses(2);
    act_once();
    pulses(2);
    chk("R7 reload postpones expiry", tmo_sts, 1'b0);
    pulses(1);
    chk("R7 expiry after reload", tmo_sts, 1'b1);

    // R7: activity ignored when disabled
    act_rl_en = 1'b0;
    strobe_load();
    pulses(2);
    act_once();
    pulses(1);
    chk("R7 activity ignored", tmo_sts, 1'b1);

    // R8 / R10: activity flag and irq routing
    strobe_load();
    act_once();
    chk("R8 act_sts set", act_sts, 1'b1);
    chk("R8 irq masked", irq, 1'b0);
    act_irq_en = 1'b1;
    #1 chk("R8 irq enabled", irq, 1'b1);
    @(negedge clk) clr_tmo = 1'b1;
    @(negedge clk) clr_tmo = 1'b0;
    chk("R10 clr_tmo leaves act_sts", act_sts, 1'b1);
    @(negedge clk) begin clr_act = 1'b1; act_pulse = 1'b1; end
    @(negedge clk) begin clr_act = 1'b0; act_pulse = 1'b0; end
    chk("R10 set wins over clear", act_sts, 1'b1);
    @(negedge clk) clr_act = 1'b1;
    @(negedge clk) clr_act = 1'b0;
    chk("R10 clr_act clears", act_sts, 1'b0);
    chk("R8 irq drops", irq, 1'b0);
    act_irq_en = 1'b0;

    // R9: timeout routed to irq
    set_mode(2'b01, 8'd1, 1'b0);
    strobe_load();
    pulses(1);
    chk("R9 irq masked", irq, 1'b0);
    tmo_irq_en = 1'b1;
    #1 chk("R9 irq from timeout", irq, 1'b1);
    @(negedge clk) clr_act = 1'b1;
    @(negedge clk) clr_act = 1'b0;
    chk("R10 clr_act leaves tmo_sts", tmo_sts, 1'b1);
    tmo_irq_en = 1'b0;

    // R11: base change restarts prescaler
    set_mode(2'b10, 8'd1, 1'b0);
    strobe_load();
    pulses(10);
    set_mode(2'b11, 8'd1, 1'b0);
    set_mode(2'b10, 8'd1, 1'b0);
    pulses(15);
    chk("R11 no early tick", tmo_sts, 1'b0);
    pulses(1);
    chk("R11 full period", tmo_sts, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule